// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that counts in its own slow clock domain and emits a one-cycle reset request when software fails to refresh it in time. Software talks to it over a small register bus in the main clock domain. Every action that matters is triggered by writing a 16-bit key value to the key address. One key opens the configuration registers for writing. Another key starts the timer. A third key refreshes the count. Once running, nothing stops it.

The bus side holds a lock state machine with two states, `LK_CLOSED` and `LK_OPEN`. A key write of 0x5555 moves `LK_CLOSED` to `LK_OPEN`. Any other key write moves `LK_OPEN` back to `LK_CLOSED`.

The slow side holds a counting state machine with three states:
- From `ST_STOPPED` it goes to `ST_COUNTING` on the start key, or straight out of reset when the hardware-start strap is high.
- From `ST_COUNTING` it goes to `ST_FIRE` when a prescaler tick finds the counter at zero.
- From `ST_FIRE` it goes back to `ST_COUNTING` on the next cycle.

Configuration values cross into the slow domain through a toggle handshake. Software sees this as two busy flags.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, address 1 reads 0, address 2 reads 0xFFF and address 3 reads 0. While neither the start key nor the hardware strap has been applied, `wdt_rst_o` stays low and produces no pulse.
- R2: Address 1 holds the prescaler select in bits [2:0] and address 2 holds the reload value in bits [11:0]. A write to either is ignored unless key 0x5555 was written to address 0 earlier and no other key has been written since.
- R3: Writing any value other than 0x5555 to address 0 closes write access, including 0xAAAA and 0xCCCC.
- R4: Writing 0xCCCC to address 0 starts the timer with the counter at 0xFFF. The first pulse therefore appears about 4096·D slow-clock cycles later.
- R5: Each reset request is exactly one slow-clock cycle wide. With reload value R and divider D, consecutive requests are exactly (R+1)·D slow-clock cycles apart, because the counter reloads from R after each request.
- R6: A prescaler select of 0 to 6 divides the slow clock by 4, 8, 16, 32, 64, 128 and 256 respectively. A select of 7 also divides by 256. The select reads back as written.
- R7: Writing 0xAAAA to address 0 reloads the counter from the reload value. Refreshes spaced less than R·D slow cycles apart prevent every reset request.
- R8: Once started, no key value stops the timer, and reset requests keep recurring.
- R9: Address 3 bit 0 is set while a prescaler update is in progress and bit 1 while a reload update is in progress. Each flag is set from the accepted write until the slow domain has captured the value. A write to a field whose flag is set is dropped.
- R10: With `hw_start_i` high the timer runs from reset without any key. The first request comes about 4096·4 slow cycles after reset is released.
- R11: When a refresh and an expiring tick fall in the same slow cycle, the refresh wins. Requests are therefore always spaced by a multiple of D and by at least (R+1)·D slow cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main (bus) clock |
| wclk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| hw_start_i | input | 1 | Strap: run from reset without a start key |
| bus_sel_i | input | 1 | Bus access select |
| bus_wr_i | input | 1 | Bus write strobe (read when low) |
| bus_addr_i | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata_i | input | 16 | Bus write data |
| bus_rdata_o | output | 16 | Bus read data, combinational on the address |
| wdt_rst_o | output | 1 | Reset request, one slow-clock pulse, registered in the slow domain |

## Verification
A refresh arriving through the synchronizer can land in the same slow cycle as the prescaler tick that would expire the counter. Which one takes effect decides whether a request fires. The bench provokes this with a divider of 4 and a reload of 1, issuing refreshes at spacings that step through many phases of the slow clock, some shorter and some longer than the timeout. Every observed gap between requests is then judged against the rule that it must be a whole multiple of D and no shorter than (R+1)·D. A double action (a fire plus a reload) would break this rule.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_START   = 16'hCCCC;

    localparam logic [1:0] A_KEY  = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_RLD  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    // Smallest divider is 4 (shift 2); largest select shift is 6 (divide by 256)
    localparam int MAX_SHIFT = 6;
    localparam int PRE_W     = MAX_SHIFT + 2;

    typedef enum logic {LK_CLOSED, LK_OPEN} lock_state_t;
    typedef enum logic [1:0] {ST_STOPPED = 2'd0, ST_COUNTING = 2'd1, ST_FIRE = 2'd2} wd_state_t;
endpackage

// File: rtl/kwd_sync.sv
module kwd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel_i,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [15:0]      bus_wdata_i,
    output logic [15:0]      bus_rdata_o,
    input  logic             div_ack_s,
    input  logic             rld_ack_s,
    output logic [SEL_W-1:0] div_sel_q,
    output logic [CNT_W-1:0] reload_q,
    output logic             div_req_t,
    output logic             rld_req_t,
    output logic             start_q,
    output logic             refresh_t
);
    lock_state_t lock_st, lock_nx;
    logic key_wr, cfg_open, cfg_wr, div_busy, rld_busy;

    always_comb begin
        key_wr   = bus_sel_i && bus_wr_i && (bus_addr_i == A_KEY);
        div_busy = div_req_t ^ div_ack_s;
        rld_busy = rld_req_t ^ rld_ack_s;
    end

    // Lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_st <= LK_CLOSED;
        else        lock_st <= lock_nx;
    end

    always_comb begin
        lock_nx = lock_st;
        unique case (lock_st)
            LK_CLOSED: if (key_wr && bus_wdata_i == KEY_UNLOCK) lock_nx = LK_OPEN;
            LK_OPEN:   if (key_wr && bus_wdata_i != KEY_UNLOCK) lock_nx = LK_CLOSED;
            default:   lock_nx = LK_CLOSED;
        endcase
    end

    // Lock outputs
    always_comb begin
        cfg_open = (lock_st == LK_OPEN);
        cfg_wr   = bus_sel_i && bus_wr_i && cfg_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_sel_q <= '0;
            div_req_t <= 1'b0;
            reload_q  <= '1;
            rld_req_t <= 1'b0;
            start_q   <= 1'b0;
            refresh_t <= 1'b0;
        end else begin
            if (cfg_wr && bus_addr_i == A_DIV && !div_busy) begin
                div_sel_q <= bus_wdata_i[SEL_W-1:0];
                div_req_t <= ~div_req_t;
            end
            if (cfg_wr && bus_addr_i == A_RLD && !rld_busy) begin
                reload_q  <= bus_wdata_i[CNT_W-1:0];
                rld_req_t <= ~rld_req_t;
            end
            if (key_wr && bus_wdata_i == KEY_START)   start_q   <= 1'b1;
            if (key_wr && bus_wdata_i == KEY_REFRESH) refresh_t <= ~refresh_t;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_DIV:   bus_rdata_o[SEL_W-1:0] = div_sel_q;
            A_RLD:   bus_rdata_o[CNT_W-1:0] = reload_q;
            A_STAT:  bus_rdata_o[1:0]       = {rld_busy, div_busy};
            default: bus_rdata_o = '0;
        endcase
    end

    p_locked_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_wr_i && bus_addr_i == A_DIV && lock_st == LK_CLOSED) |=> $stable(div_sel_q));
    p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && bus_wdata_i != KEY_UNLOCK) |=> (lock_st == LK_CLOSED));
    p_start_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && bus_wdata_i == KEY_START) |=> start_q);
    p_start_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> start_q);
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && bus_addr_i == A_RLD && rld_busy) |=> ($stable(reload_q) && $stable(rld_req_t)));
endmodule

// File: rtl/kwd_core.sv
module kwd_core
    import kwd_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEL_W = 3
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             hw_start_i,
    input  logic             run_s,
    input  logic             refresh_s,
    input  logic             div_req_s,
    input  logic             rld_req_s,
    input  logic [SEL_W-1:0] div_sel_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             div_ack_t,
    output logic             rld_ack_t,
    output logic             wdt_rst_o
);
    wd_state_t        st, st_nx;
    logic [CNT_W-1:0] cnt, reload_cfg;
    logic [SEL_W-1:0] div_cfg;
    logic [PRE_W-1:0] pre_cnt, pre_lim;
    logic             refresh_d, refresh_hit, tick, expire, go;

    function automatic logic [PRE_W-1:0] div_limit(input logic [SEL_W-1:0] s);
        logic [SEL_W-1:0] c;
        c = (s > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : s;
        return PRE_W'((4 << c) - 1);
    endfunction

    always_comb begin
        go          = run_s | hw_start_i;
        refresh_hit = (refresh_s ^ refresh_d) && (st != ST_STOPPED);
        pre_lim     = div_limit(div_cfg);
        tick        = (st != ST_STOPPED) && (pre_cnt >= pre_lim);
        expire      = tick && (cnt == '0) && !refresh_hit;
    end

    // State register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st <= ST_STOPPED;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_STOPPED:           st_nx = go ? ST_COUNTING : ST_STOPPED;
            ST_COUNTING, ST_FIRE: st_nx = expire ? ST_FIRE : ST_COUNTING;
            default:              st_nx = ST_STOPPED;
        endcase
    end

    // Output register: high exactly while in ST_FIRE
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) wdt_rst_o <= 1'b0;
        else        wdt_rst_o <= (st_nx == ST_FIRE);
    end

    // Configuration capture through the toggle handshake
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            div_cfg    <= '0;
            div_ack_t  <= 1'b0;
            reload_cfg <= '1;
            rld_ack_t  <= 1'b0;
            refresh_d  <= 1'b0;
        end else begin
            refresh_d <= refresh_s;
            if (div_req_s != div_ack_t) begin
                div_cfg   <= div_sel_i;
                div_ack_t <= div_req_s;
            end
            if (rld_req_s != rld_ack_t) begin
                reload_cfg <= reload_i;
                rld_ack_t  <= rld_req_s;
            end
        end
    end

    // Prescaler and down counter
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            cnt     <= '1;
        end else if (st == ST_STOPPED) begin
            pre_cnt <= '0;
            if (go) cnt <= '1;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
            if (refresh_hit)  cnt <= reload_cfg;
            else if (tick)    cnt <= (cnt == '0) ? reload_cfg : cnt - 1'b1;
        end
    end

    p_quiet_idle_r1: assert property (@(posedge wclk) disable iff (!rst_n)
        (st == ST_STOPPED) |-> !wdt_rst_o);
    p_start_full_r4: assert property (@(posedge wclk) disable iff (!rst_n)
        (st == ST_STOPPED && go) |=> (cnt == '1));
    p_single_pulse_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);
    p_fire_at_zero_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> ($past(cnt) == '0));
    p_refresh_load_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        refresh_hit |=> (cnt == $past(reload_cfg)));
    p_no_stop_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        (st != ST_STOPPED) |=> (st != ST_STOPPED));
    p_refresh_wins_r11: assert property (@(posedge wclk) disable iff (!rst_n)
        refresh_hit |=> !wdt_rst_o);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEL_W = 3
) (
    input  logic        clk,
    input  logic        wclk,
    input  logic        rst_n,
    input  logic        hw_start_i,
    input  logic        bus_sel_i,
    input  logic        bus_wr_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [15:0] bus_wdata_i,
    output logic [15:0] bus_rdata_o,
    output logic        wdt_rst_o
);
    logic [SEL_W-1:0] div_sel_q;
    logic [CNT_W-1:0] reload_q;
    logic div_req_t, rld_req_t, start_q, refresh_t;
    logic div_ack_t, rld_ack_t;
    logic [3:0] fwd_s;
    logic [1:0] back_s;

    kwd_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .div_ack_s(back_s[0]), .rld_ack_s(back_s[1]),
        .div_sel_q(div_sel_q), .reload_q(reload_q),
        .div_req_t(div_req_t), .rld_req_t(rld_req_t),
        .start_q(start_q), .refresh_t(refresh_t)
    );

    kwd_sync #(.W(4), .STAGES(2)) u_sync_fwd (
        .clk(wclk), .rst_n(rst_n),
        .d_i({rld_req_t, div_req_t, refresh_t, start_q}), .q_o(fwd_s)
    );

    kwd_core #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_core (
        .wclk(wclk), .rst_n(rst_n), .hw_start_i(hw_start_i),
        .run_s(fwd_s[0]), .refresh_s(fwd_s[1]),
        .div_req_s(fwd_s[2]), .rld_req_s(fwd_s[3]),
        .div_sel_i(div_sel_q), .reload_i(reload_q),
        .div_ack_t(div_ack_t), .rld_ack_t(rld_ack_t),
        .wdt_rst_o(wdt_rst_o)
    );

    kwd_sync #(.W(2), .STAGES(2)) u_sync_back (
        .clk(clk), .rst_n(rst_n),
        .d_i({rld_ack_t, div_ack_t}), .q_o(back_s)
    );
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
    localparam logic [15:0] K_OPEN = 16'h5555, K_REF = 16'hAAAA, K_GO = 16'hCCCC;

    logic clk = 1'b0, wclk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0, bus_rdata, hw_rdata;
    logic wrst, hw_rst;

    int n_cmp = 0, n_bad = 0;
    longint wtick = 0, t_last = 0, t_prev = 0, hw_first = 0, t_rel = 0;
    int npulse = 0, width_err = 0;
    logic prev_rst = 1'b0;
    logic coll_on = 1'b0, coll_armed = 1'b0;
    int coll_bad = 0, coll_seen = 0;

    always #5 clk = ~clk;
    always #13 wclk = ~wclk;

    keyed_watchdog i_keyed_watchdog (
        .clk(clk), .wclk(wclk), .rst_n(rst_n), .hw_start_i(1'b0),
        .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .wdt_rst_o(wrst)
    );

    keyed_watchdog i_keyed_watchdog_hw (
        .clk(clk), .wclk(wclk), .rst_n(rst_n), .hw_start_i(1'b1),
        .bus_sel_i(1'b0), .bus_wr_i(1'b0), .bus_addr_i(2'd0),
        .bus_wdata_i(16'h0), .bus_rdata_o(hw_rdata), .wdt_rst_o(hw_rst)
    );

    // Pulse monitor in the slow domain
    always @(negedge wclk) begin
        wtick++;
        if (wrst) begin
            npulse++;
            t_prev = t_last;
            t_last = wtick;
            if (coll_on) begin
                if (coll_armed) begin
                    coll_seen++;
                    if (((t_last - t_prev) % 4) != 0 || (t_last - t_prev) < 8) coll_bad++;
                end
                coll_armed = 1'b1;
            end
        end
        if (wrst && prev_rst) width_err++;
        prev_rst = wrst;
        if (hw_rst && hw_first == 0) hw_first = wtick;
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input longint act, input longint lo, input longint hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 100; i++) begin
            bus_read(2'd3, s);
            if (s == 16'h0) break;
        end
    endtask

    task automatic wait_pulses(input int n);
        int target;
        target = npulse + n;
        while (npulse < target) @(negedge wclk);
    endtask

    task automatic configure(input int sel, input int rl);
        bus_write(2'd0, K_OPEN);
        bus_write(2'd1, 16'(sel));
        wait_idle();
        bus_write(2'd2, 16'(rl));
        wait_idle();
        bus_write(2'd0, K_REF);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        longint t0;
        int base;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_rel = wtick;

        // R1 reset state and idle
        bus_read(2'd1, rd); check("R1 prescaler reset", rd, 0);
        bus_read(2'd2, rd); check("R1 reload reset", rd, 16'hFFF);
        bus_read(2'd3, rd); check("R1 status reset", rd, 0);
        repeat (200) @(negedge wclk);
        check("R1 no pulse before start", npulse, 0);

        // R2 writes ignored while locked
        bus_write(2'd1, 16'd5);
        bus_write(2'd2, 16'd7);
        bus_read(2'd1, rd); check("R2 locked prescaler", rd, 0);
        bus_read(2'd2, rd); check("R2 locked reload", rd, 16'hFFF);
        bus_read(2'd3, rd); check("R2 locked no busy", rd, 0);

        // R9 busy flag and dropped write
        bus_write(2'd0, K_OPEN);
        bus_write(2'd1, 16'd2);
        bus_read(2'd3, rd); check("R9 prescaler busy bit0", rd, 1);
        bus_write(2'd1, 16'd3);
        wait_idle();
        bus_read(2'd1, rd); check("R9 write while busy dropped", rd, 2);

        // R3 relock with arbitrary key
        bus_write(2'd0, 16'h1234);
        bus_write(2'd1, 16'd4);
        bus_read(2'd1, rd); check("R3 relock by other key", rd, 2);
        // R3 relock by refresh key
        bus_write(2'd0, K_OPEN);
        bus_write(2'd0, K_REF);
        bus_write(2'd1, 16'd4);
        bus_read(2'd1, rd); check("R3 relock by refresh key", rd, 2);
        bus_write(2'd0, K_OPEN);
        bus_write(2'd1, 16'd0);
        wait_idle();

        // R4 start from 0xFFF, start key also relocks (R3)
        t0 = wtick;
        bus_write(2'd0, K_GO);
        bus_write(2'd1, 16'd6);
        bus_read(2'd1, rd); check("R3 relock by start key", rd, 0);
        wait_pulses(1);
        check_range("R4 first timeout after start", t_last - t0, 16384, 16394);
        check_range("R10 hardware start first timeout", hw_first - t_rel, 16382, 16390);

        // R5 / R6 sweep over every select and two reload values
        for (int sel = 0; sel < 8; sel++) begin
            for (int ri = 0; ri < 2; ri++) begin
                int rl, dv;
                rl = (ri == 0) ? 0 : 3;
                dv = 4 << ((sel > 6) ? 6 : sel);
                bus_write(2'd0, K_OPEN);
                bus_write(2'd1, 16'(sel));
                wait_idle();
                bus_write(2'd2, 16'(rl));
                if (sel == 0 && ri == 1) begin
                    bus_read(2'd3, rd); check("R9 reload busy bit1", rd, 2);
                end
                wait_idle();
                bus_read(2'd1, rd); check("R6 select readback", rd, sel);
                bus_read(2'd2, rd); check("R2 reload readback when open", rd, rl);
                bus_write(2'd0, K_REF);
                wait_pulses(3);
                check("R5 R6 timeout period", t_last - t_prev, longint'((rl + 1) * dv));
            end
        end
        check("R5 pulse width one cycle", width_err, 0);

        // R7 regular refresh holds off reset
        configure(0, 15);
        repeat (10) @(negedge wclk);
        base = npulse;
        for (int k = 0; k < 20; k++) begin
            repeat (70) @(negedge clk);
            bus_write(2'd0, K_REF);
        end
        check("R7 refresh prevents timeout", npulse, base);
        repeat (200) @(negedge wclk);
        check("R7 timeout resumes without refresh", (npulse > base) ? 1 : 0, 1);

        // R11 refresh colliding with expiry
        configure(0, 1);
        repeat (10) @(negedge wclk);
        coll_armed = 1'b0;
        coll_on = 1'b1;
        for (int k = 0; k < 60; k++) begin
            repeat (((k * 13) % 38) + 3) @(negedge clk);
            bus_write(2'd0, K_REF);
        end
        repeat (40) @(negedge wclk);
        coll_on = 1'b0;
        check("R11 collision spacing violations", coll_bad, 0);
        check("R11 collision intervals observed", (coll_seen > 0) ? 1 : 0, 1);

        // R8 no key stops the timer
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'hFFFF);
        bus_write(2'd0, K_OPEN);
        bus_write(2'd0, 16'h0000);
        base = npulse;
        repeat (100) @(negedge wclk);
        check("R8 timer keeps running", (npulse >= base + 5) ? 1 : 0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule